// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This block carries out the two return-from-exception sequences of a processor core. The sequences are an interrupt return (RTI) and a return to user space (RTU). When `start_i` is seen in the idle state, the block latches the return kind, the current privilege mode and the native address-width code. It then pulls bytes one at a time over a simple pop port. The port raises `pop_req_o` and accepts a byte on each clock edge where `pop_valid_i` is high. Stack-pointer movement and memory access are handled outside the block.

For RTI, the first byte popped is the low status byte, and its bit 5 selects the frame format. A clear bit 5 marks an extended frame. The next byte is the extended status, whose bits [1:0] code the width of the return address and whose bit 2 is the user-mode bit. A set bit 5 marks a compatibility frame. The return address then has the native width and the mode does not change. For RTU, the extended status is the first byte, and the low status is never restored. The return address is assembled least significant byte first, and it is sign-extended when it is narrower than the configured width.

The control sequence runs through five states. `ST_IDLE` waits for a start. `ST_POP_LOW` takes the low status. `ST_POP_EXT` takes the extended status. `ST_POP_ADDR` collects the address bytes. `ST_FINISH` is a single cycle that presents the result. The transitions are:
- start with RTU in user mode: idle to finish, aborted;
- start with RTU in kernel mode: idle to pop-ext;
- start with RTI: idle to pop-low;
- low byte accepted with bit 5 clear: pop-low to pop-ext;
- low byte accepted with bit 5 set: pop-low to pop-addr;
- privilege escalation detected: pop-ext to finish;
- extended byte accepted otherwise: pop-ext to pop-addr;
- last address byte accepted: pop-addr to finish;
- finish to idle.

Top module: `frame_unwinder`

## Requirements
- R1: In RTI, the first byte popped is the low status byte. On a successful return, `ld_low_o` is 1 and `status_o` equals that byte with bit 2 (the interrupt-disable flag) forced to 0.
- R2: When an RTI's low status byte has bit 5 equal to 0, the next byte popped is the extended status. The address width is taken from that byte's bits [1:0], coded as 00 = 2 bytes, 01 = 4 bytes, 10 or 11 = 8 bytes. `ld_ext_o` is 1, `ext_status_o` holds the byte, and `user_mode_o` equals its bit 2.
- R3: When the block runs in user mode (`user_mode_i` = 1) and an RTI extended status has bit 2 equal to 0, the result is `abort_o` = 1 with `abort_cause_o` = 1 (privileged RTI). No address byte is popped.
- R4: When an RTI's low status byte has bit 5 equal to 1, the address width comes from `native_wcode_i` (same coding as R2). In that case `user_mode_o` equals the mode latched at start, and `ld_ext_o` is 0.
- R5: An RTU started in user mode pops nothing. It gives `done_o` = `abort_o` = 1 with `abort_cause_o` = 2 (privileged operation) in the cycle after the start.
- R6: An RTU in kernel mode pops the extended status first, then the address at that byte's width. `ld_low_o` stays 0, `ld_ext_o` is 1, and `user_mode_o` equals bit 2 of that byte.
- R7: The first address byte popped becomes bits [7:0] of `target_o`, and each following byte fills the next higher 8 bits. Bytes beyond `ADDR_W` are dropped. An address narrower than `ADDR_W` is sign-extended from its top bit.
- R8: While `abort_o` is 1, `ld_low_o`, `ld_ext_o` and `ld_pc_o` are all 0.
- R9: A byte is taken only on a clock edge where both `pop_req_o` and `pop_valid_i` are high. A start that arrives while a sequence runs is ignored, as are changes of the mode and kind inputs. `done_o` is a single-cycle pulse.
- R10: After reset, `pop_req_o`, `done_o` and `abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a return sequence (sampled when idle) |
| kind_i | input | 1 | 0 = RTI, 1 = RTU |
| user_mode_i | input | 1 | Current mode is user |
| native_wcode_i | input | 2 | Native address-width code for compatibility frames |
| pop_req_o | output | 1 | Block wants the next stack byte |
| pop_valid_i | input | 1 | Stack byte present on `pop_data_i` |
| pop_data_i | input | 8 | Popped byte |
| done_o | output | 1 | Sequence complete (one cycle) |
| abort_o | output | 1 | Sequence ended in a privilege abort |
| abort_cause_o | output | 2 | 0 none, 1 privileged RTI, 2 privileged operation |
| ld_low_o | output | 1 | Load restored low status |
| status_o | output | 8 | Restored low status |
| ld_ext_o | output | 1 | Load restored extended status |
| ext_status_o | output | 8 | Restored extended status |
| ld_pc_o | output | 1 | Take the jump and the new mode |
| user_mode_o | output | 1 | Mode after return |
| target_o | output | ADDR_W | Jump target |

## Verification
The privilege check on an extended frame is decided on the same edge that accepts the extended status byte. The bench therefore presents that byte with random gaps in `pop_valid_i`, and checks that the abort appears with no further pops and with all load enables low. During a pop state, a new start can also land while a byte is being accepted. The bench raises `start_i` and flips the kind and mode inputs in the second cycle of a running sequence. It then checks that the pop count, the mode and the target still match the sequence started first.

// File: rtl/frame_unwinder_pkg.sv
package frame_unwinder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP_LOW,
        ST_POP_EXT,
        ST_POP_ADDR,
        ST_FINISH
    } unw_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PRIVRTI = 2'd1,
        CAUSE_PRIVOP  = 2'd2
    } abort_cause_t;

    localparam int FRAME_MARK_BIT = 5;
    localparam int IRQ_OFF_BIT    = 2;
    localparam int EXT_USER_BIT   = 2;

    function automatic logic [3:0] wcode_bytes(input logic [1:0] code);
        unique case (code)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/frame_addr_acc.sv
module frame_addr_acc #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [3:0]        idx_i,
    input  logic [7:0]        byte_i,
    input  logic [3:0]        nbytes_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int ADDR_BYTES = ADDR_W / 8;

    logic [ADDR_W-1:0] raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (clear_i) begin
            raw_q <= '0;
        end else if (load_i) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (idx_i == 4'(b)) raw_q[8*b +: 8] <= byte_i;
            end
        end
    end

    // sign extension from the top popped bit when narrower than ADDR_W
    always_comb begin
        int   top;
        logic sbit;
        top  = 8 * int'(nbytes_i) - 1;
        sbit = 1'b0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i == top) sbit = raw_q[i];
        end
        for (int i = 0; i < ADDR_W; i++) begin
            target_o[i] = (i <= top) ? raw_q[i] : sbit;
        end
    end

endmodule

// File: rtl/frame_unwinder.sv
module frame_unwinder
    import frame_unwinder_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              kind_i,
    input  logic              user_mode_i,
    input  logic [1:0]        native_wcode_i,
    output logic              pop_req_o,
    input  logic              pop_valid_i,
    input  logic [7:0]        pop_data_i,
    output logic              done_o,
    output logic              abort_o,
    output logic [1:0]        abort_cause_o,
    output logic              ld_low_o,
    output logic [7:0]        status_o,
    output logic              ld_ext_o,
    output logic [7:0]        ext_status_o,
    output logic              ld_pc_o,
    output logic              user_mode_o,
    output logic [ADDR_W-1:0] target_o
);
    localparam logic KIND_RTU = 1'b1;

    unw_state_t   state_q, state_d;
    logic         kind_q, umode_q, ext_frame_q, abort_q;
    logic [1:0]   nwc_q;
    logic [7:0]   low_q, ext_q;
    logic [3:0]   cnt_q, nbytes_q;
    abort_cause_t cause_q;
    logic         take;
    logic         escalate;
    logic         acc_clear;

    assign take     = pop_req_o && pop_valid_i;
    assign escalate = (kind_q != KIND_RTU) && umode_q && !pop_data_i[EXT_USER_BIT];
    assign acc_clear = (state_q == ST_IDLE) && start_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                if (kind_i == KIND_RTU) state_d = user_mode_i ? ST_FINISH : ST_POP_EXT;
                else                    state_d = ST_POP_LOW;
            end
            ST_POP_LOW: if (pop_valid_i)
                state_d = pop_data_i[FRAME_MARK_BIT] ? ST_POP_ADDR : ST_POP_EXT;
            ST_POP_EXT: if (pop_valid_i)
                state_d = escalate ? ST_FINISH : ST_POP_ADDR;
            ST_POP_ADDR: if (pop_valid_i && cnt_q == nbytes_q - 4'd1)
                state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= 1'b0; umode_q <= 1'b0; nwc_q <= 2'b00;
            ext_frame_q <= 1'b0; abort_q <= 1'b0; cause_q <= CAUSE_NONE;
            low_q <= '0; ext_q <= '0; cnt_q <= '0; nbytes_q <= 4'd2;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    kind_q      <= kind_i;
                    umode_q     <= user_mode_i;
                    nwc_q       <= native_wcode_i;
                    ext_frame_q <= (kind_i == KIND_RTU);
                    abort_q     <= (kind_i == KIND_RTU) && user_mode_i;
                    cause_q     <= ((kind_i == KIND_RTU) && user_mode_i) ? CAUSE_PRIVOP : CAUSE_NONE;
                    low_q       <= '0;
                    ext_q       <= '0;
                    cnt_q       <= '0;
                end
                ST_POP_LOW: if (pop_valid_i) begin
                    low_q <= pop_data_i;
                    if (pop_data_i[FRAME_MARK_BIT]) nbytes_q <= wcode_bytes(nwc_q);
                    else                            ext_frame_q <= 1'b1;
                end
                ST_POP_EXT: if (pop_valid_i) begin
                    ext_q <= pop_data_i;
                    if (escalate) begin
                        abort_q <= 1'b1;
                        cause_q <= CAUSE_PRIVRTI;
                    end else begin
                        nbytes_q <= wcode_bytes(pop_data_i[1:0]);
                    end
                end
                ST_POP_ADDR: if (pop_valid_i) cnt_q <= cnt_q + 4'd1;
                default: ;
            endcase
        end
    end

    frame_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (acc_clear),
        .load_i   (take && state_q == ST_POP_ADDR),
        .idx_i    (cnt_q),
        .byte_i   (pop_data_i),
        .nbytes_i (nbytes_q),
        .target_o (target_o)
    );

    // outputs
    always_comb begin
        pop_req_o     = (state_q == ST_POP_LOW) || (state_q == ST_POP_EXT) || (state_q == ST_POP_ADDR);
        done_o        = (state_q == ST_FINISH);
        abort_o       = done_o && abort_q;
        abort_cause_o = abort_o ? cause_q : CAUSE_NONE;
        ld_pc_o       = done_o && !abort_q;
        ld_low_o      = ld_pc_o && (kind_q != KIND_RTU);
        ld_ext_o      = ld_pc_o && ext_frame_q;
        status_o      = low_q;
        status_o[IRQ_OFF_BIT] = 1'b0;
        ext_status_o  = ext_q;
        user_mode_o   = ext_frame_q ? ext_q[EXT_USER_BIT] : umode_q;
    end

    // assertions
    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !(ld_low_o || ld_ext_o || ld_pc_o));

    assert_rtu_user_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && kind_i && user_mode_i)
        |=> (abort_o && abort_cause_o == CAUSE_PRIVOP && !pop_req_o));

    assert_escalate_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP_EXT && pop_valid_i && !kind_q && umode_q && !pop_data_i[EXT_USER_BIT])
        |=> (abort_o && abort_cause_o == CAUSE_PRIVRTI));

    assert_rtu_no_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pc_o && kind_q) |-> (!ld_low_o && ld_ext_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_pop_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pop_req_o);

endmodule

// File: tb/sim_frame_unwinder.sv
`timescale 1ns/1ps
module sim_frame_unwinder;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, kind_i = 1'b0, user_mode_i = 1'b0;
    logic [1:0] native_wcode_i = 2'b00;
    logic pop_valid_i = 1'b0;
    logic [7:0] pop_data_i = 8'h00;
    logic pop_req_o, done_o, abort_o, ld_low_o, ld_ext_o, ld_pc_o, user_mode_o;
    logic [1:0] abort_cause_o;
    logic [7:0] status_o, ext_status_o;
    logic [AW-1:0] target_o;

    always #2.5 clk = ~clk;

    frame_unwinder #(.ADDR_W(AW)) u0 (.*);

    int nchk = 0, nfail = 0;
    logic [7:0] fbuf [0:15];
    bit e_abort, e_ldlow, e_ldext, e_mode;
    logic [1:0] e_cause;
    logic [7:0] e_status, e_ext;
    logic [AW-1:0] e_target;
    int e_pops;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbytes(input logic [1:0] c);
        return (c == 2'b00) ? 2 : (c == 2'b01) ? 4 : 8;
    endfunction

    task automatic predict(input bit k, input bit u, input logic [1:0] nw);
        int idx, nb;
        logic [63:0] raw;
        e_abort = 0; e_cause = 0; e_ldlow = 0; e_ldext = 0; e_mode = u;
        e_status = 0; e_ext = 0; idx = 0; nb = 0;
        if (!k) begin
            e_status = fbuf[0] & 8'hFB; idx = 1;
            if (!fbuf[0][5]) begin
                e_ext = fbuf[1]; idx = 2;
                if (u && !fbuf[1][2]) begin e_abort = 1; e_cause = 2'd1; end
                else begin nb = wbytes(fbuf[1][1:0]); e_mode = fbuf[1][2]; e_ldext = 1; end
            end else nb = wbytes(nw);
            e_ldlow = !e_abort;
        end else if (u) begin
            e_abort = 1; e_cause = 2'd2;
        end else begin
            e_ext = fbuf[0]; idx = 1; nb = wbytes(fbuf[0][1:0]);
            e_mode = fbuf[0][2]; e_ldext = 1;
        end
        raw = '0;
        for (int i = 0; i < nb; i++) raw[8*i +: 8] = fbuf[idx+i];
        if (nb > 0 && nb < 8 && raw[8*nb-1]) raw = raw | (~64'h0 << (8*nb));
        e_target = raw[AW-1:0];
        e_pops = idx + nb;
    endtask

    task automatic run_op(input bit k, input bit u, input logic [1:0] nw, input bit stray);
        int p, cyc;
        bit seen;
        predict(k, u, nw);
        @(negedge clk);
        kind_i = k; user_mode_i = u; native_wcode_i = nw; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; p = 0; cyc = 1; seen = 0;
        while (!seen && cyc < 200) begin
            if (done_o) begin
                seen = 1;
                pop_valid_i = 1'b0; start_i = 1'b0;
            end else begin
                if (pop_req_o && ($urandom % 4 != 0) && p < 16) begin
                    pop_valid_i = 1'b1; pop_data_i = fbuf[p]; p++;
                end else begin
                    pop_valid_i = 1'b0; pop_data_i = 8'($urandom);
                end
                if (stray && cyc == 2) begin
                    start_i = 1'b1; kind_i = ~k; user_mode_i = ~u; native_wcode_i = ~nw;
                end else start_i = 1'b0;
                @(negedge clk);
                cyc++;
            end
        end
        kind_i = k; user_mode_i = u; native_wcode_i = nw;
        check(seen, "R9 done seen", 64'(seen), 64'd1);
        check(p == e_pops, "R9 pop count", 64'(p), 64'(e_pops));
        check(abort_o == e_abort && abort_cause_o == e_cause, k ? "R5 abort/cause" : "R3 abort/cause",
              {abort_o, abort_cause_o}, {e_abort, e_cause});
        check(ld_low_o == e_ldlow && ld_ext_o == e_ldext && ld_pc_o == !e_abort, "R8 load enables",
              {ld_low_o, ld_ext_o, ld_pc_o}, {e_ldlow, e_ldext, !e_abort});
        if (k && u) check(cyc == 1, "R5 abort latency", 64'(cyc), 64'd1);
        if (!e_abort) begin
            check(target_o == e_target, "R7 target", 64'(target_o), 64'(e_target));
            check(user_mode_o == e_mode, e_ldext ? "R2 mode" : "R4 mode", 64'(user_mode_o), 64'(e_mode));
        end
        if (e_ldlow) check(status_o == e_status, "R1 status", 64'(status_o), 64'(e_status));
        if (e_ldext) check(ext_status_o == e_ext, "R6 ext status", 64'(ext_status_o), 64'(e_ext));
        @(negedge clk);
        check(!done_o, "R9 done pulse", 64'(done_o), 64'd0);
    endtask

    task automatic set_buf(input logic [7:0] b0, b1, b2, b3, b4, b5);
        for (int i = 0; i < 16; i++) fbuf[i] = 8'(i * 17 + 3);
        fbuf[0] = b0; fbuf[1] = b1; fbuf[2] = b2; fbuf[3] = b3; fbuf[4] = b4; fbuf[5] = b5;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                nfail++; nchk++;
                $display("FAIL R9 watchdog actual=%0d expected<150000", wd);
                $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) fbuf[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!pop_req_o && !done_o && !abort_o, "R10 in reset", {pop_req_o, done_o, abort_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pop_req_o && !done_o && !abort_o, "R10 after reset", {pop_req_o, done_o, abort_o}, 0);

        // R2: extended RTI, 4-byte address, kernel to user
        set_buf(8'h04, 8'h05, 8'h11, 8'h22, 8'h33, 8'h84);
        run_op(1'b0, 1'b0, 2'b00, 1'b0);
        // R4: compatibility RTI in user mode, two bytes, sign extension R7
        set_buf(8'h24, 8'h34, 8'h92, 8'h00, 8'h00, 8'h00);
        run_op(1'b0, 1'b1, 2'b00, 1'b0);
        // R3: user-mode escalation attempt
        set_buf(8'h00, 8'h01, 8'hAA, 8'hBB, 8'h00, 8'h00);
        run_op(1'b0, 1'b1, 2'b01, 1'b0);
        // R5: RTU in user mode
        set_buf(8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        run_op(1'b1, 1'b1, 2'b00, 1'b0);
        // R6: RTU 8-byte address truncated to AW (R7)
        set_buf(8'h06, 8'h78, 8'h56, 8'h34, 8'h12, 8'hEE);
        run_op(1'b1, 1'b0, 2'b00, 1'b0);
        // R6: RTU 2-byte negative address
        set_buf(8'h04, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00);
        run_op(1'b1, 1'b0, 2'b00, 1'b1);
        // R9: stray start during compat RTI
        set_buf(8'hFF, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50);
        run_op(1'b0, 1'b0, 2'b01, 1'b1);

        for (int n = 0; n < 80; n++) begin
            for (int i = 0; i < 16; i++) fbuf[i] = 8'($urandom);
            run_op(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule